// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block watches eight external interrupt request pins. Each pin has its own two-bit sense code, which picks one of four detection modes: low level, falling edge, rising edge, or either edge. When the selected condition occurs, the block sets that channel's status flag. All eight flags sit in one 8-bit status register on a simple single-cycle CPU bus. Each flag, ANDed with a per-channel enable bit, drives an active-high interrupt output.

A flag clears in one of two ways. Software can clear it, but only by first reading the flag as 1 and then writing 0 to it. Hardware clears it when the interrupt controller pulses the channel's accept input. In low-level mode, that automatic clear happens only if the synchronised pin is already high. Channels 7 to 4 also have an inhibit bit that blocks the automatic clear. Every pin passes through a two-flop synchroniser before detection.

Each channel holds a small two-state machine that tracks the read-before-write rule:
- **ARM_IDLE**: the reset state.
- **ARM_IDLE → ARM_READY** (transition *arm*): taken when a status read, with no status write in the same cycle, returns 1 for that bit.
- **ARM_READY → ARM_IDLE** (transition *disarm*): taken on any status write, whatever data it carries.
- In ARM_READY, a status write with a 0 in that bit clears the flag.
- Every other case holds the current state.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset, all flags, the sense codes, the enable register and the inhibit register read 0, and `irq_out` is 0.
- R2: The bus map is as follows. Address 0 is status. Address 1 holds the sense codes of channels 3..0, with channel n at bits [2n+1:2n]. Address 2 holds the sense codes of channels 7..4 at the same positions (channel n-4 slot). Address 3 is enable. Address 4 is inhibit. The sense code values are 00 = low level, 01 = falling edge, 10 = rising edge and 11 = both edges.
- R3: In low-level mode, a pin held low sets its flag, and the flag can be read within four clock cycles of the pin change.
- R4: In edge modes, the flag sets only on the selected edge: falling for 01, rising for 10, either edge for 11. Holding the pin at a steady level does not set the flag.
- R5: Writing 1 to a status bit leaves that flag unchanged.
- R6: Writing 0 to a status bit clears the flag only if a status read returned 1 for that bit before the write, with no status write in between. Any status write ends that permission.
- R7: Pulsing `irq_ack[n]` in an edge mode clears flag n on the next clock.
- R8: Pulsing `irq_ack[n]` in low-level mode clears flag n only if the synchronised pin is high; while the pin is low, the flag stays 1.
- R9: Inhibit bits 7..4 at address 4 stop `irq_ack` from clearing the flag. Inhibit bits 3..0 read 0, and writing them has no effect.
- R10: When a set condition and a clear occur in the same cycle, the flag ends up 1.
- R11: `irq_out[n]` equals flag n AND enable bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Asynchronous interrupt request pins |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; the register updates at the clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when `bus_rd` is low |
| irq_ack | input | 8 | Per-channel interrupt-accepted pulse |
| irq_out | output | 8 | Per-channel active-high interrupt request |

## Verification
The hardest conditions to reach from the ports are the clear attempts whose outcome depends on history rather than on the value being written. These include:
- a write of 0 after the permission was cancelled by an intervening write of 1;
- a clear that collides with a pin still held low in level mode;
- an accept pulse on an inhibited channel.

The bench reaches each of these with explicit bus sequences. The first is a read, then a write of 0xFF, then a write of 0. It also sweeps every channel through all four sense codes, applying a falling and then a rising pin transition with a software clear after each. The expected flag byte is computed from the mode code.

// File: rtl/eif_pkg.sv
package eif_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_t;

    typedef enum logic {
        ARM_IDLE  = 1'b0,
        ARM_READY = 1'b1
    } arm_t;

    localparam int STAT_ADDR = 0;
    localparam int SNS_BASE  = 1;
endpackage

// File: rtl/eif_sync.sv
module eif_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/eif_channel.sv
module eif_channel
    import eif_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_t sense,
    input  logic   inhibit,
    input  logic   ack,
    input  logic   rd_stat,
    input  logic   wr_stat,
    input  logic   wbit,
    output logic   flag
);
    logic prev_q;
    logic set_cond;
    logic hw_clr;
    logic sw_clr;
    arm_t arm_q;
    arm_t arm_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_s;
    end

    always_comb begin
        set_cond = 1'b0;
        unique case (sense)
            SENSE_LOW:  set_cond = !pin_s;
            SENSE_FALL: set_cond = prev_q && !pin_s;
            SENSE_RISE: set_cond = !prev_q && pin_s;
            SENSE_BOTH: set_cond = prev_q ^ pin_s;
        endcase
    end

    assign hw_clr = ack && !inhibit && ((sense != SENSE_LOW) || pin_s);

    // read-before-write tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= ARM_IDLE;
        else        arm_q <= arm_d;
    end

    // read-before-write tracker: transitions
    always_comb begin
        arm_d = arm_q;
        unique case (arm_q)
            ARM_IDLE:  if (rd_stat && !wr_stat && flag) arm_d = ARM_READY;
            ARM_READY: if (wr_stat) arm_d = ARM_IDLE;
        endcase
    end

    // read-before-write tracker: output
    always_comb begin
        sw_clr = 1'b0;
        unique case (arm_q)
            ARM_IDLE:  sw_clr = 1'b0;
            ARM_READY: sw_clr = wr_stat && !wbit;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                flag <= 1'b0;
        else if (set_cond)         flag <= 1'b1;
        else if (sw_clr || hw_clr) flag <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_cond |=> flag);
    a_r5_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_stat && wbit && !ack) |=> flag);
    a_r6_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_stat && arm_q == ARM_IDLE && !ack) |=> flag);
    a_r7_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack && !inhibit && sense != SENSE_LOW && !set_cond) |=> !flag);
    a_r8_low_pin_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack && sense == SENSE_LOW && !pin_s && !wr_stat) |=> flag);
    a_r9_inhibit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack && inhibit && !wr_stat) |=> flag);
endmodule

// File: rtl/eif_regs.sv
module eif_regs
    import eif_pkg::*;
#(
    parameter int              NUM_CH   = 8,
    parameter int              ADDR_W   = 3,
    parameter logic [NUM_CH-1:0] INH_MASK = 8'hF0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NUM_CH-1:0]     bus_wdata,
    input  logic [NUM_CH-1:0]     flags,
    output logic [NUM_CH-1:0]     bus_rdata,
    output logic [2*NUM_CH-1:0]   sense,
    output logic [NUM_CH-1:0]     enable,
    output logic [NUM_CH-1:0]     inhibit,
    output logic                  rd_stat,
    output logic                  wr_stat
);
    localparam int SNS_BYTES = NUM_CH / 4;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(SNS_BASE + SNS_BYTES);
    localparam logic [ADDR_W-1:0] A_INH  = ADDR_W'(SNS_BASE + SNS_BYTES + 1);

    assign rd_stat = bus_rd && (bus_addr == A_STAT);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense   <= '0;
            enable  <= '0;
            inhibit <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_EN)  enable  <= bus_wdata;
            if (bus_addr == A_INH) inhibit <= bus_wdata & INH_MASK;
            for (int k = 0; k < SNS_BYTES; k++) begin
                if (bus_addr == ADDR_W'(SNS_BASE + k)) sense[8*k +: 8] <= bus_wdata[7:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_STAT)     bus_rdata = flags;
            else if (bus_addr == A_EN)  bus_rdata = enable;
            else if (bus_addr == A_INH) bus_rdata = inhibit;
            else begin
                for (int k = 0; k < SNS_BYTES; k++) begin
                    if (bus_addr == ADDR_W'(SNS_BASE + k)) bus_rdata[7:0] = sense[8*k +: 8];
                end
            end
        end
    end

    a_r9_inhibit_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_INH) |=> ((inhibit & ~INH_MASK) == '0));
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
    import eif_pkg::*;
#(
    parameter int                NUM_CH   = 8,
    parameter int                ADDR_W   = 3,
    parameter logic [NUM_CH-1:0] INH_MASK = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_pin,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] irq_ack,
    output logic [NUM_CH-1:0] irq_out
);
    logic [NUM_CH-1:0]   pin_s;
    logic [NUM_CH-1:0]   flags;
    logic [2*NUM_CH-1:0] sense;
    logic [NUM_CH-1:0]   enable;
    logic [NUM_CH-1:0]   inhibit;
    logic                rd_stat;
    logic                wr_stat;

    eif_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .INH_MASK(INH_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .flags(flags), .bus_rdata(bus_rdata),
        .sense(sense), .enable(enable), .inhibit(inhibit),
        .rd_stat(rd_stat), .wr_stat(wr_stat)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        eif_sync #(.RST_VAL(1'b1)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(irq_pin[n]), .dout(pin_s[n])
        );
        eif_channel u_chan (
            .clk(clk), .rst_n(rst_n), .pin_s(pin_s[n]),
            .sense(sense_t'(sense[2*n +: 2])), .inhibit(inhibit[n]),
            .ack(irq_ack[n]), .rd_stat(rd_stat), .wr_stat(wr_stat),
            .wbit(bus_wdata[n]), .flag(flags[n])
        );
    end

    assign irq_out = flags & enable;

    a_r11_out_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~enable) == '0));
endmodule

// File: tb/test_ext_irq_flags.sv
`timescale 1ns/1ps
module test_ext_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_pin = 8'hFF;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_ack = 8'h00;
    logic [7:0] irq_out;

    int checks = 0;
    int fails = 0;
    logic [15:0] sns_shadow = 16'h0000;

    always #2.5 clk = ~clk;

    ext_irq_flags i_ext_irq_flags (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_pin(input int ch, input logic v);
        @(negedge clk);
        irq_pin[ch] = v;
        settle();
    endtask

    task automatic set_mode(input int ch, input logic [1:0] m);
        sns_shadow[2*ch +: 2] = m;
        bus_write(3'd1, sns_shadow[7:0]);
        bus_write(3'd2, sns_shadow[15:8]);
    endtask

    task automatic sw_clear();
        logic [7:0] d;
        bus_read(3'd0, d);
        bus_write(3'd0, 8'h00);
    endtask

    task automatic pulse_ack(input int ch);
        @(negedge clk);
        irq_ack[ch] = 1'b1;
        @(negedge clk);
        irq_ack[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic stat(output logic [7:0] d);
        bus_read(3'd0, d);
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: reset state
        stat(d);              check("R1 status", d, 8'h00);
        bus_read(3'd1, d);    check("R1 sense lo", d, 8'h00);
        bus_read(3'd2, d);    check("R1 sense hi", d, 8'h00);
        bus_read(3'd3, d);    check("R1 enable", d, 8'h00);
        bus_read(3'd4, d);    check("R1 inhibit", d, 8'h00);
        check("R1 irq_out", irq_out, 8'h00);

        // R2: sense register layout read-back
        bus_write(3'd1, 8'hE4);
        bus_read(3'd1, d);    check("R2 sense lo readback", d, 8'hE4);
        bus_write(3'd2, 8'h1B);
        bus_read(3'd2, d);    check("R2 sense hi readback", d, 8'h1B);
        stat(d);              check("R2 status untouched", d, 8'h00);
        bus_write(3'd1, 8'h00);
        bus_write(3'd2, 8'h00);

        // R3 R4 R10: sweep every channel through every sense code
        for (int ch = 0; ch < 8; ch++) begin
            for (int m = 0; m < 4; m++) begin
                set_mode(ch, 2'(m));
                set_pin(ch, 1'b0);
                stat(d);
                e = ((m == 0) || (m == 1) || (m == 3)) ? 8'(1 << ch) : 8'h00;
                check((m == 0) ? "R3 low level set" : "R4 falling pin", d, e);
                sw_clear();
                stat(d);
                e = (m == 0) ? 8'(1 << ch) : 8'h00;
                check("R10 clear with pin low", d, e);
                set_pin(ch, 1'b1);
                stat(d);
                e = ((m == 0) || (m == 2) || (m == 3)) ? 8'(1 << ch) : 8'h00;
                check("R4 rising pin", d, e);
                sw_clear();
                stat(d);
                check("R6 clear after read", d, 8'h00);
            end
            set_mode(ch, 2'd0);
        end

        // R5 R6: write rules on channel 1, falling mode
        set_mode(1, 2'd1);
        set_pin(1, 1'b0);
        set_pin(1, 1'b1);
        bus_write(3'd0, 8'h00);
        stat(d);              check("R6 zero without read", d, 8'h02);
        bus_write(3'd0, 8'hFF);
        stat(d);              check("R5 write one", d, 8'h02);
        bus_write(3'd0, 8'hFF);
        bus_write(3'd0, 8'h00);
        stat(d);              check("R6 permission ended by write", d, 8'h02);
        sw_clear();
        stat(d);              check("R6 read then zero", d, 8'h00);
        // a read of 0 grants nothing: read, then set, then write 0
        stat(d);
        set_pin(1, 1'b0);
        bus_write(3'd0, 8'h00);
        stat(d);              check("R6 read of zero", d, 8'h02);
        sw_clear();
        set_pin(1, 1'b1);
        set_mode(1, 2'd0);

        // R7: accept in edge mode clears
        set_mode(3, 2'd1);
        set_pin(3, 1'b0);
        stat(d);              check("R7 flag before ack", d, 8'h08);
        pulse_ack(3);
        stat(d);              check("R7 edge ack clears", d, 8'h00);
        set_pin(3, 1'b1);
        set_mode(3, 2'd0);

        // R8: accept in level mode
        set_pin(0, 1'b0);
        pulse_ack(0);
        stat(d);              check("R8 ack with pin low", d, 8'h01);
        set_pin(0, 1'b1);
        stat(d);              check("R8 flag held after pin high", d, 8'h01);
        pulse_ack(0);
        stat(d);              check("R8 ack with pin high", d, 8'h00);

        // R9: inhibit
        bus_write(3'd4, 8'hFF);
        bus_read(3'd4, d);    check("R9 inhibit low bits zero", d, 8'hF0);
        set_mode(5, 2'd1);
        set_mode(2, 2'd1);
        set_pin(5, 1'b0);
        set_pin(2, 1'b0);
        pulse_ack(5);
        pulse_ack(2);
        stat(d);              check("R9 inhibit holds ch5, not ch2", d, 8'h20);
        sw_clear();
        stat(d);              check("R9 software clear on inhibited", d, 8'h00);
        bus_write(3'd4, 8'h00);
        set_pin(5, 1'b1);
        set_pin(2, 1'b1);

        // R11: output gating
        set_mode(1, 2'd1);
        set_pin(5, 1'b0);
        set_pin(2, 1'b0);
        set_pin(1, 1'b0);
        check("R11 no enable", irq_out, 8'h00);
        bus_write(3'd3, 8'h24);
        @(negedge clk);
        check("R11 gated output", irq_out, 8'h24);
        stat(d);              check("R11 flags", d, 8'h26);
        sw_clear();
        @(negedge clk);
        check("R11 output after clear", irq_out, 8'h00);

        finish_test();
    end
endmodule